// File: doc/BRIEF.md
# Tick-Polled Clock Interrupt Emulator

This block rebuilds the interrupt flags of a time-of-day clock chip when that chip's interrupt line has been given to another timer. A fixed-rate tick, 64 Hz by default, strobes the block. On each tick it polls the current hours, minutes and seconds supplied by separate timekeeping logic. It then decides which of three sources fire: an update source on each new second, an alarm source on a time-of-day match, and a periodic source that divides the tick down for slower requested rates.

Software programs the source enables, the alarm time and the periodic divide limit through a small synchronous write port. The tick comparator also reports how many ticks it skipped while catching up with the main counter. Those skipped ticks are folded into the periodic divider so that the periodic rate does not drift. The result is a packed flag word with a one-cycle strobe for the downstream interrupt consumer. When no source is enabled, the tick channel is treated as disarmed. A pulse marks the moment it is armed again.

Top module: `rtc_irq_emulator`

## Requirements
- R1: After reset, `irq_word` is 0, `irq_strobe` is 0, `tick_armed` is 0 and `rearm` is 0. The recorded seconds value and the periodic count are 0.
- R2: On a tick with update enabled, word bit 4 is set only if `cur_sec` differs from the recorded seconds value. That `cur_sec` then becomes the recorded value. The reset value is 0.
- R3: On a tick with alarm enabled, word bit 5 is set when `cur_hr`, `cur_min` and `cur_sec` all equal the programmed alarm time.
- R4: On a tick with periodic enabled, the periodic count becomes count + `lost_ticks` + 1. When that sum is greater than or equal to the divide limit, word bit 6 is set and the count returns to 0. A limit of 0 or 1 fires on every tick.
- R5: `lost_ticks` has no effect unless periodic is enabled on that tick. In that case the count holds its value.
- R6: When any of bits 4..6 is set, bit 7 is also set and bits [15:8] hold 1. `irq_strobe` is high for that one cycle, which is the cycle after the clock edge that samples the tick. A tick that raises no flag gives `irq_word` = 0 and no strobe.
- R7: While all three enables are clear, `tick_armed` is 0 and ticks are ignored. No strobe is produced, and neither the recorded seconds nor the periodic count changes.
- R8: A write that takes the enables from all-clear to non-zero raises `rearm` for exactly one cycle, the cycle after the write edge. `tick_armed` follows the OR of the enables.
- R9: A write and a tick sampled on the same edge: the tick is judged with the enables in force before the write.
- R10: Write select 0 loads the enables (data bit 0 update, bit 1 alarm, bit 2 periodic). Select 1 loads the alarm time as seconds in [5:0], minutes in [11:6] and hours in [16:12]. Select 2 loads the divide limit from the low bits. Select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle polling tick from the comparator |
| lost_ticks | input | LOST_W | Ticks skipped by the comparator, valid with `tick` |
| cur_hr | input | HR_W | Current hours |
| cur_min | input | MIN_W | Current minutes |
| cur_sec | input | SEC_W | Current seconds |
| wr_en | input | 1 | Write strobe of the programming port |
| wr_sel | input | 2 | Target select: 0 enables, 1 alarm time, 2 divide limit, 3 none |
| wr_data | input | HR_W+MIN_W+SEC_W | Write data |
| irq_word | output | 16 | Packed flag word |
| irq_strobe | output | 1 | Flag word valid, one cycle |
| tick_armed | output | 1 | At least one source enabled |
| rearm | output | 1 | One-cycle pulse when leaving the all-clear state |

## Verification
Update and alarm can fire on the same tick. This happens when the polled time reaches the alarm second at the moment the seconds value changes. The bench arranges this by programming an alarm and ticking at exactly that time with a fresh seconds value, and it expects a single word that carries both bits 4 and 5 along with the shared header. A write to the enables that lands on the same edge as a tick is also provoked. That tick must be judged with the old enables, and the next tick must show the new ones.

// File: rtl/rtc_emu_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the tick-polled clock interrupt emulator.
// Assumes: flag bit positions are fixed by the downstream consumer.
package rtc_emu_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_ALARM  = 2'd1,
        SEL_LIMIT  = 2'd2,
        SEL_SPARE  = 2'd3
    } wr_sel_e;

    // Source enables, packed so that bit 0 is update, bit 1 alarm, bit 2 periodic.
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } src_en_t;

    localparam int WORD_W   = 16;
    localparam int BIT_UPD  = 4;
    localparam int BIT_ALM  = 5;
    localparam int BIT_PER  = 6;
    localparam int BIT_REQ  = 7;
    localparam logic [7:0] IRQ_COUNT = 8'd1;

endpackage

// File: rtl/rtc_emu_regs.sv
`timescale 1ns/1ps
// Programming registers: enables, alarm time and periodic divide limit.
// Assumes: a single-cycle write strobe; select 3 is reserved and ignored.
// The rearm pulse marks a write that leaves the all-clear enable state.
module rtc_emu_regs
    import rtc_emu_pkg::*;
#(
    parameter int HR_W  = 5,
    parameter int MIN_W = 6,
    parameter int SEC_W = 6,
    parameter int LIM_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [HR_W+MIN_W+SEC_W-1:0]  wr_data,
    output src_en_t                      en_q,
    output logic [HR_W-1:0]              alm_hr_q,
    output logic [MIN_W-1:0]             alm_min_q,
    output logic [SEC_W-1:0]             alm_sec_q,
    output logic [LIM_W-1:0]             lim_q,
    output logic                         rearm_q
);
    localparam int MIN_LSB = SEC_W;
    localparam int HR_LSB  = SEC_W + MIN_W;

    wr_sel_e sel;
    src_en_t new_en;

    assign sel    = wr_sel_e'(wr_sel);
    assign new_en = src_en_t'(wr_data[2:0]);

    // Register file update on the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            alm_hr_q  <= '0;
            alm_min_q <= '0;
            alm_sec_q <= '0;
            lim_q     <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ENABLE: en_q <= new_en;
                SEL_ALARM: begin
                    alm_sec_q <= wr_data[SEC_W-1:0];
                    alm_min_q <= wr_data[MIN_LSB +: MIN_W];
                    alm_hr_q  <= wr_data[HR_LSB +: HR_W];
                end
                SEL_LIMIT:  lim_q <= wr_data[LIM_W-1:0];
                default:    ;
            endcase
        end
    end

    // One-cycle pulse when enables go from all-clear to non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rearm_q <= 1'b0;
        end else begin
            rearm_q <= wr_en && (sel == SEL_ENABLE) &&
                       (en_q == '0) && (new_en != '0);
        end
    end

endmodule

// File: rtl/rtc_emu_update.sv
`timescale 1ns/1ps
// Update source: flags a tick whose seconds value differs from the last
// recorded one, then records it. Assumes: go is already qualified by arming.
module rtc_emu_update #(
    parameter int SEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             enable,
    input  logic [SEC_W-1:0] cur_sec,
    output logic             hit
);
    logic [SEC_W-1:0] last_sec_q;

    assign hit = go && enable && (cur_sec != last_sec_q);

    // Record the seconds value that raised the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sec_q <= '0;
        end else if (hit) begin
            last_sec_q <= cur_sec;
        end
    end

endmodule

// File: rtl/rtc_emu_alarm.sv
`timescale 1ns/1ps
// Alarm source: compares the polled time of day with the programmed alarm.
// Assumes: both times use the same field encoding; purely combinational.
module rtc_emu_alarm #(
    parameter int HR_W  = 5,
    parameter int MIN_W = 6,
    parameter int SEC_W = 6
) (
    input  logic             go,
    input  logic             enable,
    input  logic [HR_W-1:0]  cur_hr,
    input  logic [MIN_W-1:0] cur_min,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic [HR_W-1:0]  alm_hr,
    input  logic [MIN_W-1:0] alm_min,
    input  logic [SEC_W-1:0] alm_sec,
    output logic             hit
);
    logic match;

    // Full time-of-day equality.
    always_comb begin
        match = (cur_hr == alm_hr) && (cur_min == alm_min) && (cur_sec == alm_sec);
        hit   = go && enable && match;
    end

endmodule

// File: rtl/rtc_emu_periodic.sv
`timescale 1ns/1ps
// Periodic source: divides the tick by a programmed limit, counting skipped
// ticks as elapsed ones. Assumes: lost_ticks is valid only together with go.
module rtc_emu_periodic #(
    parameter int LIM_W  = 8,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              enable,
    input  logic [LOST_W-1:0] lost_ticks,
    input  logic [LIM_W-1:0]  limit,
    output logic              hit
);
    localparam int SUM_W = ((LIM_W > LOST_W) ? LIM_W : LOST_W) + 1;

    logic [LIM_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;
    logic             step;

    // Next count including skipped ticks and the current one.
    always_comb begin
        step = go && enable;
        sum  = SUM_W'(cnt_q) + SUM_W'(lost_ticks) + SUM_W'(1);
        hit  = step && (sum >= SUM_W'(limit));
    end

    // Divider state: clear on a hit, otherwise keep the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= sum[LIM_W-1:0];
        end
    end

endmodule

// File: rtl/rtc_irq_emulator.sv
`timescale 1ns/1ps
// Top of the tick-polled clock interrupt emulator. Gates the tick by the
// arming state, gathers the three sources and registers the flag word.
// Assumes: tick is a single-cycle pulse; the time inputs are stable with it.
module rtc_irq_emulator
    import rtc_emu_pkg::*;
#(
    parameter int HR_W   = 5,
    parameter int MIN_W  = 6,
    parameter int SEC_W  = 6,
    parameter int LIM_W  = 8,
    parameter int LOST_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic [LOST_W-1:0]            lost_ticks,
    input  logic [HR_W-1:0]              cur_hr,
    input  logic [MIN_W-1:0]             cur_min,
    input  logic [SEC_W-1:0]             cur_sec,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [HR_W+MIN_W+SEC_W-1:0]  wr_data,
    output logic [15:0]                  irq_word,
    output logic                         irq_strobe,
    output logic                         tick_armed,
    output logic                         rearm
);
    src_en_t          en_q;
    logic [HR_W-1:0]  alm_hr_q;
    logic [MIN_W-1:0] alm_min_q;
    logic [SEC_W-1:0] alm_sec_q;
    logic [LIM_W-1:0] lim_q;
    logic             go;
    logic             upd_hit;
    logic             alm_hit;
    logic             per_hit;

    rtc_emu_regs #(
        .HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W), .LIM_W(LIM_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .en_q(en_q), .alm_hr_q(alm_hr_q), .alm_min_q(alm_min_q),
        .alm_sec_q(alm_sec_q), .lim_q(lim_q), .rearm_q(rearm)
    );

    assign tick_armed = |en_q;
    assign go         = tick && tick_armed;

    rtc_emu_update #(.SEC_W(SEC_W)) u_upd (
        .clk(clk), .rst_n(rst_n), .go(go), .enable(en_q.upd),
        .cur_sec(cur_sec), .hit(upd_hit)
    );

    rtc_emu_alarm #(.HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)) u_alm (
        .go(go), .enable(en_q.alm),
        .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_hr(alm_hr_q), .alm_min(alm_min_q), .alm_sec(alm_sec_q),
        .hit(alm_hit)
    );

    rtc_emu_periodic #(.LIM_W(LIM_W), .LOST_W(LOST_W)) u_per (
        .clk(clk), .rst_n(rst_n), .go(go), .enable(en_q.per),
        .lost_ticks(lost_ticks), .limit(lim_q), .hit(per_hit)
    );

    // Register the packed flag word and its strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_word   <= '0;
            irq_strobe <= 1'b0;
        end else if (upd_hit || alm_hit || per_hit) begin
            irq_word          <= '0;
            irq_word[15:8]    <= IRQ_COUNT;
            irq_word[BIT_REQ] <= 1'b1;
            irq_word[BIT_PER] <= per_hit;
            irq_word[BIT_ALM] <= alm_hit;
            irq_word[BIT_UPD] <= upd_hit;
            irq_strobe        <= 1'b1;
        end else begin
            irq_word   <= '0;
            irq_strobe <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_emu_checker.sv
`timescale 1ns/1ps
// Protocol checker for the emulator, bound onto the top module.
module rtc_emu_checker #(
    parameter int HR_W  = 5,
    parameter int MIN_W = 6,
    parameter int SEC_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [2:0]       en,
    input logic [HR_W-1:0]  cur_hr,
    input logic [MIN_W-1:0] cur_min,
    input logic [SEC_W-1:0] cur_sec,
    input logic [HR_W-1:0]  alm_hr,
    input logic [MIN_W-1:0] alm_min,
    input logic [SEC_W-1:0] alm_sec,
    input logic [15:0]      word,
    input logic             strobe,
    input logic             armed,
    input logic             rearm
);
    assert_strobe_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(tick));

    assert_word_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (word[7] && (word[15:8] == 8'd1) && (word[6:4] != 3'b000)));

    assert_quiet_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> (word == 16'd0));

    assert_update_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && word[4]) |-> $past(en[0]));

    assert_alarm_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && word[5]) |-> $past(en[1] && (cur_hr == alm_hr) &&
                                       (cur_min == alm_min) && (cur_sec == alm_sec)));

    assert_periodic_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && word[6]) |-> $past(en[2]));

    assert_disarmed_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!armed) |-> !strobe);

    assert_rearm_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |-> (($past(en) == 3'b000) && (en != 3'b000)));

    assert_rearm_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !rearm);

endmodule

bind rtc_irq_emulator rtc_emu_checker #(
    .HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q),
    .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_hr(alm_hr_q), .alm_min(alm_min_q), .alm_sec(alm_sec_q),
    .word(irq_word), .strobe(irq_strobe), .armed(tick_armed), .rearm(rearm)
);

// File: tb/rtc_irq_emulator_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each tick and queues the expected word,
// the monitor pops and compares once the design has registered its result.
module rtc_irq_emulator_test;
    localparam int HR_W = 5, MIN_W = 6, SEC_W = 6, LIM_W = 8, LOST_W = 8;
    localparam int DW = HR_W + MIN_W + SEC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [LOST_W-1:0] lost_ticks = '0;
    logic [HR_W-1:0]   cur_hr = '0;
    logic [MIN_W-1:0]  cur_min = '0;
    logic [SEC_W-1:0]  cur_sec = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [15:0]       irq_word;
    logic              irq_strobe;
    logic              tick_armed;
    logic              rearm;

    rtc_irq_emulator #(.HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W),
                       .LIM_W(LIM_W), .LOST_W(LOST_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lost_ticks(lost_ticks),
        .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_word(irq_word), .irq_strobe(irq_strobe),
        .tick_armed(tick_armed), .rearm(rearm)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench-side model state.
    logic [2:0] m_en = '0;
    int m_ahr = 0, m_amin = 0, m_asec = 0;
    int m_lim = 0, m_last = 0, m_cnt = 0;
    bit exp_rearm = 1'b0;

    logic [15:0] qw[$];
    string       qt[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of one tick, evaluated with the enables in force before any write.
    task automatic model_tick(input int hr, input int mi, input int se, input int lost,
                              input string tag);
        bit u = 0, a = 0, p = 0;
        logic [15:0] w;
        if (m_en != 3'b000) begin
            if (m_en[0] && (se != m_last)) begin
                u = 1; m_last = se;
            end
            if (m_en[1] && hr == m_ahr && mi == m_amin && se == m_asec) a = 1;
            if (m_en[2]) begin
                if (m_cnt + lost + 1 >= m_lim) begin
                    p = 1; m_cnt = 0;
                end else begin
                    m_cnt = m_cnt + lost + 1;
                end
            end
        end
        w = (u || a || p) ? {8'd1, 1'b1, p, a, u, 4'b0000} : 16'd0;
        qw.push_back(w);
        qt.push_back(tag);
    endtask

    task automatic model_write(input int sel, input int data);
        exp_rearm = 1'b0;
        case (sel)
            0: begin
                exp_rearm = (m_en == 3'b000) && (data[2:0] != 3'b000);
                m_en = data[2:0];
            end
            1: begin
                m_asec = data & 63; m_amin = (data >> 6) & 63; m_ahr = (data >> 12) & 31;
            end
            2: m_lim = data & 255;
            default: ;
        endcase
    endtask

    // Driver: one sampled cycle carrying an optional tick and an optional write.
    task automatic step(input bit t, input int hr, input int mi, input int se, input int lost,
                        input bit w, input int sel, input int data, input string tag);
        @(posedge clk); #1;
        tick = t; cur_hr = HR_W'(hr); cur_min = MIN_W'(mi); cur_sec = SEC_W'(se);
        lost_ticks = LOST_W'(lost);
        wr_en = w; wr_sel = 2'(sel); wr_data = DW'(data);
        if (t) model_tick(hr, mi, se, lost, tag);
        if (w) model_write(sel, data);
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0; lost_ticks = '0;
        if (w) begin
            check(rearm == exp_rearm, {tag, " R8 rearm"}, rearm, exp_rearm);
            check(tick_armed == (m_en != 0), {tag, " R8 armed"}, tick_armed, (m_en != 0));
        end
    endtask

    task automatic tk(input int hr, input int mi, input int se, input int lost, input string tag);
        step(1'b1, hr, mi, se, lost, 1'b0, 0, 0, tag);
    endtask

    task automatic wr(input int sel, input int data, input string tag);
        step(1'b0, 0, 0, 0, 0, 1'b1, sel, data, tag);
    endtask

    // Monitor: compare the word one cycle after each sampled tick.
    bit pend = 1'b0;
    always @(negedge clk) begin
        if (pend) begin
            logic [15:0] ew;
            string et;
            ew = qw.pop_front();
            et = qt.pop_front();
            check(irq_word == ew && irq_strobe == (ew != 0), et, {irq_strobe, irq_word},
                  {(ew != 0), ew});
        end
        pend = tick;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(irq_word == 0 && irq_strobe == 0, "R1 word", {irq_strobe, irq_word}, 0);
        check(tick_armed == 0 && rearm == 0, "R1 armed", {tick_armed, rearm}, 0);

        // R7: ticks ignored while disarmed; seconds 5 must not be recorded
        tk(0, 0, 5, 3, "R7 disarmed tick");
        check(tick_armed == 0, "R7 armed low", tick_armed, 0);

        // R8, R10: enable update only (bit 0)
        wr(0, 1, "R10 enable update");
        tk(0, 0, 5, 0, "R2 new second");
        tk(0, 0, 5, 0, "R2 same second");
        tk(0, 0, 6, 0, "R2 next second");
        wr(0, 3, "R8 no rearm when already armed");

        // R3, R10: alarm at 01:02:03, concurrent with update
        wr(1, (1 << 12) | (2 << 6) | 3, "R10 alarm write");
        tk(1, 2, 3, 0, "R3 alarm with update");
        tk(1, 2, 4, 0, "R3 seconds past alarm");
        tk(1, 3, 3, 0, "R3 minute mismatch");
        tk(2, 2, 4, 0, "R3 hour mismatch");
        wr(0, 2, "R3 alarm only");
        tk(1, 2, 3, 0, "R3 alarm alone");

        // R4: periodic divide by 4
        wr(2, 4, "R10 limit write");
        wr(0, 4, "R10 periodic only");
        for (int i = 0; i < 8; i++) tk(0, 0, 9, 0, "R4 divide by four");
        // R5: lost ticks count toward the divider
        tk(0, 0, 9, 2, "R5 lost ticks added");
        tk(0, 0, 9, 0, "R5 limit reached after loss");
        tk(0, 0, 9, 1, "R5 partial");
        // R5: lost ticks ignored while periodic is off
        wr(0, 1, "R5 periodic off");
        tk(0, 0, 10, 40, "R5 lost ignored");
        wr(0, 4, "R5 periodic back on");
        tk(0, 0, 10, 0, "R5 count held");
        tk(0, 0, 10, 0, "R5 count held next");

        // R4: limits 1 and 0 fire every tick
        wr(2, 1, "R4 limit one");
        tk(0, 0, 10, 0, "R4 limit one a");
        tk(0, 0, 10, 0, "R4 limit one b");
        wr(2, 0, "R4 limit zero");
        tk(0, 0, 10, 0, "R4 limit zero");

        // R9: write that clears enables on the same edge as a tick
        wr(0, 5, "R9 setup");
        step(1'b1, 0, 0, 20, 0, 1'b1, 0, 0, "R9 old enables used");
        tk(0, 0, 21, 0, "R9 new enables used");
        check(tick_armed == 0, "R7 after clear", tick_armed, 0);

        // R10: select 3 writes change nothing
        wr(3, 7, "R10 spare select");
        tk(0, 0, 22, 0, "R10 spare ignored");
        // R8: rearm from all-clear, recorded seconds still 20
        wr(0, 1, "R8 rearm");
        tk(0, 0, 20, 0, "R7 no record while disarmed");
        tk(0, 0, 23, 0, "R2 after rearm");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule